// File: doc/BRIEF.md
# Register Busy-Bit Wakeup Unit

This block sits beside the rename and issue logic of an out-of-order core. It keeps one busy bit for every physical register. Rename sets a bit when it hands a register out as a destination, and writeback clears it. An instruction whose source operands are not all available is parked in a waiting slot. The slot remembers which sources are still missing and holds a 2-bit count of them. Together, the slots that name a given register form that register's queue of waiters.

When writeback names a register, the block clears its busy bit and visits every waiter parked on it. It drops each matching source from the outstanding set and lowers the count. A waiter whose count reaches zero becomes ready to leave. An ordinary instruction leaves through the issue port toward the functional units. A memory instruction, whose parked sources are its address operands, leaves through the address-generation port instead. An instruction that is already complete at insertion never takes a slot and leaves on the next cycle.

At most one instruction leaves per cycle. A flush removes every waiter younger than a given instruction tag. The register values themselves live outside this block; only tags leave it.

Top module: `wake_unit`

## Requirements
- R1: After reset every busy bit is clear, neither output port is valid, and `full` is low.
- R2: An allocation sets the named busy bit and a writeback clears the named bit. Both become visible one cycle later. When both name the same register in one cycle, the bit ends up set.
- R3: At insertion a source counts as outstanding only if it is enabled and its busy bit is set. A writeback in the same cycle already counts as clearing that bit. An instruction with no outstanding source takes no slot and appears on its output port one cycle later.
- R4: Each writeback lowers the count of every waiting entry by the number of its outstanding sources that name the written register, so a register used twice drops the count by two. An entry whose count reaches zero becomes ready in that same cycle.
- R5: A ready ordinary instruction leaves with `issue_valid` high and its tag on `issue_tag`. A ready memory instruction (`ins_is_mem` = 1) leaves with `agen_valid` high and its tag on `agen_tag`. Both outputs are registered and appear one cycle after the deciding edge.
- R6: At most one instruction leaves per cycle. A same-cycle bypassing insertion takes precedence. Otherwise the ready entry with the smallest tag leaves, and the other ready entries wait for later cycles.
- R7: While `flush_valid` is high, every waiting entry whose tag is greater than `flush_tag` (unsigned comparison) is removed and never leaves, and the insertion input is ignored. Entries with tags at or below `flush_tag` are unaffected.
- R8: `full` is high exactly when every waiting slot is occupied. It falls on the cycle after a slot is freed by release or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Mark a destination register busy |
| alloc_preg | input | PREG_W | Register to mark busy |
| wb_valid | input | 1 | Writeback of a destination register |
| wb_preg | input | PREG_W | Register written back |
| ins_valid | input | 1 | Insert an instruction |
| ins_tag | input | TAG_W | Age tag of the inserted instruction (smaller is older) |
| ins_is_mem | input | 1 | Inserted instruction is a memory operation |
| ins_src0_en | input | 1 | First source is used |
| ins_src0 | input | PREG_W | First source register |
| ins_src1_en | input | 1 | Second source is used |
| ins_src1 | input | PREG_W | Second source register |
| flush_valid | input | 1 | Squash waiters younger than `flush_tag` |
| flush_tag | input | TAG_W | Youngest surviving tag |
| issue_valid | output | 1 | An ordinary instruction leaves toward issue |
| issue_tag | output | TAG_W | Its tag |
| agen_valid | output | 1 | A memory instruction leaves toward address generation |
| agen_tag | output | TAG_W | Its tag |
| busy_o | output | NUM_PREGS | Busy bit of every physical register |
| full | output | 1 | All waiting slots occupied |

## Verification
Some properties are checked on every cycle: the two output ports are never valid together, and no instruction younger than a flush point leaves after that flush. For each waiting slot, the stored count always matches the number of outstanding sources and is zero once the slot is ready. Busy bits are also checked to follow allocation and writeback. Only the bench's scenarios can show that the right instruction leaves at the right time: oldest-first order under contention, the precedence of bypassing insertions, same-cycle writeback at insertion, a register used as both sources, and slots filling up and draining. The bench drives these through directed cases and a long seeded random run, and compares against a reference model.

// File: rtl/wake_pkg.sv
package wake_pkg;

    // Control fields of one waiting slot.
    typedef struct packed {
        logic       valid;   // slot holds an instruction
        logic       rdy;     // count has reached zero, awaiting release
        logic       is_mem;  // route to address generation when released
        logic [1:0] pend;    // per-source outstanding flags
        logic [1:0] cnt;     // number of outstanding sources
    } wk_ctl_t;

    function automatic logic [1:0] pop2(input logic [1:0] v);
        return {1'b0, v[0]} + {1'b0, v[1]};
    endfunction

endpackage

// File: rtl/wake_busy_table.sv
module wake_busy_table #(
    parameter int NUM_PREGS = 32,
    localparam int PREG_W = $clog2(NUM_PREGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [PREG_W-1:0]    alloc_preg,
    input  logic                 wb_valid,
    input  logic [PREG_W-1:0]    wb_preg,
    output logic [NUM_PREGS-1:0] busy_q,
    output logic [NUM_PREGS-1:0] busy_wb
);

    logic [NUM_PREGS-1:0] busy_d;

    always_comb begin
        busy_wb = busy_q;
        if (wb_valid) busy_wb[wb_preg] = 1'b0;
        busy_d = busy_wb;
        if (alloc_valid) busy_d[alloc_preg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    // R2
    wb_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(alloc_valid && alloc_preg == wb_preg))
        |=> !busy_q[$past(wb_preg)]);

    // R2
    alloc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> busy_q[$past(alloc_preg)]);

endmodule

// File: rtl/wake_age_pick.sv
module wake_age_pick #(
    parameter int N     = 8,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][TAG_W-1:0] tags,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);

    logic [TAG_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || tags[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = tags[i];
            end
        end
    end

endmodule

// File: rtl/wake_free_find.sv
module wake_free_find #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     used,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/wake_unit.sv
module wake_unit #(
    parameter int NUM_PREGS = 32,
    parameter int NUM_SLOTS = 8,
    parameter int TAG_W     = 16,
    localparam int PREG_W = $clog2(NUM_PREGS),
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [PREG_W-1:0]    alloc_preg,
    input  logic                 wb_valid,
    input  logic [PREG_W-1:0]    wb_preg,
    input  logic                 ins_valid,
    input  logic [TAG_W-1:0]     ins_tag,
    input  logic                 ins_is_mem,
    input  logic                 ins_src0_en,
    input  logic [PREG_W-1:0]    ins_src0,
    input  logic                 ins_src1_en,
    input  logic [PREG_W-1:0]    ins_src1,
    input  logic                 flush_valid,
    input  logic [TAG_W-1:0]     flush_tag,
    output logic                 issue_valid,
    output logic [TAG_W-1:0]     issue_tag,
    output logic                 agen_valid,
    output logic [TAG_W-1:0]     agen_tag,
    output logic [NUM_PREGS-1:0] busy_o,
    output logic                 full
);
    import wake_pkg::*;

    typedef struct packed {
        wk_ctl_t [NUM_SLOTS-1:0]                ctl;
        logic [NUM_SLOTS-1:0][TAG_W-1:0]        tag;
        logic [NUM_SLOTS-1:0][1:0][PREG_W-1:0]  src;
        logic                                   iss_v;
        logic [TAG_W-1:0]                       iss_tag;
        logic                                   agn_v;
        logic [TAG_W-1:0]                       agn_tag;
    } st_t;

    st_t s_d, s_q;

    logic [NUM_PREGS-1:0] busy_wb;
    wk_ctl_t [NUM_SLOTS-1:0] ctl_upd;
    logic [NUM_SLOTS-1:0] cand;
    logic [NUM_SLOTS-1:0] used;
    logic [1:0] ins_pend;
    logic bypass, need_slot;
    logic pick_found, free_found;
    logic [SLOT_W-1:0] pick_idx, free_idx;

    wake_busy_table #(.NUM_PREGS(NUM_PREGS)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
        .wb_valid(wb_valid), .wb_preg(wb_preg),
        .busy_q(busy_o), .busy_wb(busy_wb)
    );

    // Stage 1: wakeup and flush applied to every slot.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            logic [1:0] hit;
            ctl_upd[i] = s_q.ctl[i];
            used[i]    = s_q.ctl[i].valid;
            hit = 2'b00;
            if (wb_valid && s_q.ctl[i].valid && !s_q.ctl[i].rdy) begin
                for (int k = 0; k < 2; k++)
                    hit[k] = s_q.ctl[i].pend[k] && (s_q.src[i][k] == wb_preg);
            end
            ctl_upd[i].pend = s_q.ctl[i].pend & ~hit;
            ctl_upd[i].cnt  = s_q.ctl[i].cnt - pop2(hit);
            if (s_q.ctl[i].valid && s_q.ctl[i].cnt != 2'd0 && ctl_upd[i].cnt == 2'd0)
                ctl_upd[i].rdy = 1'b1;
            if (flush_valid && s_q.ctl[i].valid && s_q.tag[i] > flush_tag) begin
                ctl_upd[i].valid = 1'b0;
                ctl_upd[i].rdy   = 1'b0;
            end
            cand[i] = ctl_upd[i].valid && ctl_upd[i].rdy;
        end
        ins_pend[0] = ins_src0_en && busy_wb[ins_src0];
        ins_pend[1] = ins_src1_en && busy_wb[ins_src1];
        bypass    = ins_valid && !flush_valid && (ins_pend == 2'b00);
        need_slot = ins_valid && !flush_valid && (ins_pend != 2'b00);
    end

    wake_age_pick #(.N(NUM_SLOTS), .TAG_W(TAG_W)) u_pick (
        .cand(cand), .tags(s_q.tag), .found(pick_found), .idx(pick_idx)
    );

    wake_free_find #(.N(NUM_SLOTS)) u_free (
        .used(used), .found(free_found), .idx(free_idx)
    );

    // Stage 2: release selection and insertion.
    always_comb begin
        s_d       = s_q;
        s_d.ctl   = ctl_upd;
        s_d.iss_v = 1'b0;
        s_d.agn_v = 1'b0;
        if (bypass) begin
            if (ins_is_mem) begin s_d.agn_v = 1'b1; s_d.agn_tag = ins_tag; end
            else            begin s_d.iss_v = 1'b1; s_d.iss_tag = ins_tag; end
        end else if (pick_found) begin
            if (ctl_upd[pick_idx].is_mem) begin
                s_d.agn_v = 1'b1; s_d.agn_tag = s_q.tag[pick_idx];
            end else begin
                s_d.iss_v = 1'b1; s_d.iss_tag = s_q.tag[pick_idx];
            end
            s_d.ctl[pick_idx].valid = 1'b0;
            s_d.ctl[pick_idx].rdy   = 1'b0;
        end
        if (need_slot && free_found) begin
            s_d.ctl[free_idx].valid  = 1'b1;
            s_d.ctl[free_idx].rdy    = 1'b0;
            s_d.ctl[free_idx].is_mem = ins_is_mem;
            s_d.ctl[free_idx].pend   = ins_pend;
            s_d.ctl[free_idx].cnt    = pop2(ins_pend);
            s_d.tag[free_idx]        = ins_tag;
            s_d.src[free_idx][0]     = ins_src0;
            s_d.src[free_idx][1]     = ins_src1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign issue_valid = s_q.iss_v;
    assign issue_tag   = s_q.iss_tag;
    assign agen_valid  = s_q.agn_v;
    assign agen_tag    = s_q.agn_tag;
    assign full        = &used;

    // R6
    one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && agen_valid));

    // R7
    flush_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !(issue_valid && issue_tag > $past(flush_tag)));

    // R7
    flush_agen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !(agen_valid && agen_tag > $past(flush_tag)));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
        // R4
        cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.ctl[g].valid && !s_q.ctl[g].rdy)
            |-> (s_q.ctl[g].cnt == $countones(s_q.ctl[g].pend) && s_q.ctl[g].cnt != 2'd0));
        // R4
        rdy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.ctl[g].valid && s_q.ctl[g].rdy) |-> s_q.ctl[g].cnt == 2'd0);
    end

endmodule

// File: tb/tb_wake_unit.sv
module tb_wake_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int NS = 8;
    localparam int TW = 16;
    localparam int PW = $clog2(NP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, wb_valid = 0, ins_valid = 0, ins_is_mem = 0;
    logic ins_src0_en = 0, ins_src1_en = 0, flush_valid = 0;
    logic [PW-1:0] alloc_preg = 0, wb_preg = 0, ins_src0 = 0, ins_src1 = 0;
    logic [TW-1:0] ins_tag = 0, flush_tag = 0;
    logic issue_valid, agen_valid, full;
    logic [TW-1:0] issue_tag, agen_tag;
    logic [NP-1:0] busy_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_unit #(.NUM_PREGS(NP), .NUM_SLOTS(NS), .TAG_W(TW)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
        .wb_valid(wb_valid), .wb_preg(wb_preg),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_is_mem(ins_is_mem),
        .ins_src0_en(ins_src0_en), .ins_src0(ins_src0),
        .ins_src1_en(ins_src1_en), .ins_src1(ins_src1),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .issue_valid(issue_valid), .issue_tag(issue_tag),
        .agen_valid(agen_valid), .agen_tag(agen_tag),
        .busy_o(busy_o), .full(full)
    );

    int n_chk = 0, n_bad = 0;
    logic [TW-1:0] next_tag = 1;

    // Reference model state
    bit [NP-1:0] m_busy;
    bit m_v[NS], m_rdy[NS], m_mem[NS];
    bit [1:0] m_pend[NS];
    bit [TW-1:0] m_tag[NS];
    bit [PW-1:0] m_s0[NS], m_s1[NS];
    bit e_iv, e_av;
    bit [TW-1:0] e_it, e_at;

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < NS; i++) if (m_v[i]) c++;
        return c;
    endfunction

    task automatic model_step();
        bit [NP-1:0] bwb;
        bit [1:0] ip;
        bit byp;
        int best;
        bwb = m_busy;
        if (wb_valid) bwb[wb_preg] = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (m_v[i] && !m_rdy[i] && wb_valid) begin
                if (m_pend[i][0] && m_s0[i] == wb_preg) m_pend[i][0] = 1'b0;
                if (m_pend[i][1] && m_s1[i] == wb_preg) m_pend[i][1] = 1'b0;
                if (m_pend[i] == 2'b00) m_rdy[i] = 1'b1;
            end
            if (flush_valid && m_v[i] && m_tag[i] > flush_tag) begin
                m_v[i] = 1'b0; m_rdy[i] = 1'b0;
            end
        end
        ip[0] = ins_src0_en && bwb[ins_src0];
        ip[1] = ins_src1_en && bwb[ins_src1];
        byp = ins_valid && !flush_valid && ip == 2'b00;
        e_iv = 0; e_av = 0;
        if (byp) begin
            if (ins_is_mem) begin e_av = 1; e_at = ins_tag; end
            else            begin e_iv = 1; e_it = ins_tag; end
        end else begin
            best = -1;
            for (int i = 0; i < NS; i++)
                if (m_v[i] && m_rdy[i] && (best < 0 || m_tag[i] < m_tag[best])) best = i;
            if (best >= 0) begin
                if (m_mem[best]) begin e_av = 1; e_at = m_tag[best]; end
                else             begin e_iv = 1; e_it = m_tag[best]; end
                m_v[best] = 0; m_rdy[best] = 0;
            end
        end
        if (ins_valid && !flush_valid && ip != 2'b00) begin
            for (int j = 0; j < NS; j++) begin
                if (!m_v[j]) begin
                    m_v[j] = 1; m_rdy[j] = 0; m_mem[j] = ins_is_mem; m_tag[j] = ins_tag;
                    m_pend[j] = ip; m_s0[j] = ins_src0; m_s1[j] = ins_src1;
                    break;
                end
            end
        end
        m_busy = bwb;
        if (alloc_valid) m_busy[alloc_preg] = 1'b1;
    endtask

    task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h exp %0h", what, got, exp);
        end
    endtask

    task automatic check_all(input string label);
        chk({label, " issue port (R5)"}, 64'({issue_valid, issue_valid ? issue_tag : '0}),
            64'({e_iv, e_iv ? e_it : '0}));
        chk({label, " agen port (R5)"}, 64'({agen_valid, agen_valid ? agen_tag : '0}),
            64'({e_av, e_av ? e_at : '0}));
        chk({label, " busy bits (R2)"}, 64'(busy_o), 64'(m_busy));
        chk({label, " full flag (R8)"}, 64'(full), 64'(m_count() == NS));
    endtask

    task automatic clear_in();
        alloc_valid = 0; wb_valid = 0; ins_valid = 0; flush_valid = 0;
        ins_is_mem = 0; ins_src0_en = 0; ins_src1_en = 0;
    endtask

    // Inputs set at negedge; model advances; outputs sampled at the next negedge.
    task automatic cyc(input string label);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(label);
        clear_in();
    endtask

    task automatic set_ins(input bit mem, input bit e0, input int s0, input bit e1, input int s1);
        ins_valid = 1; ins_is_mem = mem; ins_tag = next_tag; next_tag++;
        ins_src0_en = e0; ins_src0 = PW'(s0); ins_src1_en = e1; ins_src1 = PW'(s1);
    endtask

    task automatic do_alloc(input int r, input string label);
        alloc_valid = 1; alloc_preg = PW'(r); cyc(label);
    endtask

    task automatic do_wb(input int r, input string label);
        wb_valid = 1; wb_preg = PW'(r); cyc(label);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [TW-1:0] t_a;
        void'($urandom(32'd4242));
        m_busy = '0;
        for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_rdy[i] = 0; end
        e_iv = 0; e_av = 0; e_it = 0; e_at = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: allocations set busy bits
        for (int r = 3; r <= 11; r++) do_alloc(r, "R2 alloc");
        // R2: alloc and writeback of the same register in one cycle leaves it set
        alloc_valid = 1; alloc_preg = 12; wb_valid = 1; wb_preg = 12; cyc("R2 same-reg alloc+wb");

        // R3: instruction with two busy sources waits; ready instruction bypasses
        set_ins(0, 1, 3, 1, 4); cyc("R3 queued");
        set_ins(0, 1, 1, 1, 2); cyc("R3 bypass");
        // R4: partial then full wakeup
        do_wb(3, "R4 partial wakeup");
        do_wb(4, "R4 release");
        cyc("R4 idle");
        // R4: same register as both sources drops count by two
        set_ins(0, 1, 5, 1, 5); cyc("R4 dual-use queued");
        do_wb(5, "R4 dual-use release");
        // R5: memory instruction goes to address generation
        set_ins(1, 1, 6, 0, 0); cyc("R5 mem queued");
        do_wb(6, "R5 agen release");
        // R6: two waiters on one register plus a same-cycle bypass
        set_ins(0, 1, 7, 0, 0); cyc("R6 first waiter");
        set_ins(1, 0, 0, 1, 7); cyc("R6 second waiter");
        wb_valid = 1; wb_preg = 7; set_ins(0, 0, 0, 0, 0); cyc("R6 bypass wins");
        cyc("R6 oldest next");
        cyc("R6 younger last");
        cyc("R6 drained");
        // R7: flush keeps the oldest of three waiters
        t_a = next_tag;
        set_ins(0, 1, 9, 0, 0); cyc("R7 waiter a");
        set_ins(1, 1, 9, 0, 0); cyc("R7 waiter b");
        set_ins(0, 0, 0, 1, 9); cyc("R7 waiter c");
        flush_valid = 1; flush_tag = t_a; set_ins(0, 0, 0, 0, 0); cyc("R7 flush ignores insert");
        do_wb(9, "R7 survivor release");
        cyc("R7 nothing younger");
        // R8: fill all slots, then flush to drain
        t_a = next_tag - 1;
        for (int i = 0; i < NS; i++) begin set_ins(0, 1, 10, 0, 0); cyc("R8 filling"); end
        flush_valid = 1; flush_tag = t_a; cyc("R8 flush all");
        cyc("R8 not full");
        // R3: writeback in the insertion cycle counts as ready
        set_ins(0, 1, 11, 0, 0); wb_valid = 1; wb_preg = 11; cyc("R3 same-cycle wb");
        cyc("R3 idle");

        // Seeded random run
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 2 == 0) begin alloc_valid = 1; alloc_preg = PW'($urandom % 8); end
            if ($urandom % 2 == 0) begin wb_valid = 1; wb_preg = PW'($urandom % 8); end
            if (($urandom % 10) < 6 && m_count() < NS)
                set_ins(1'($urandom % 3 == 0), 1'($urandom % 10 < 7), int'($urandom % 8),
                        1'($urandom % 10 < 7), int'($urandom % 8));
            if ($urandom % 40 == 0) begin
                flush_valid = 1;
                flush_tag = next_tag - TW'(1) - TW'($urandom % 4);
            end
            cyc("R4/R6/R7 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule